// File: doc/BRIEF.md
# Segment Translation Fault Classifier

This block decides the outcome of one address translation in a 32-bit segmented memory-management unit. Each request carries an effective address, the access kind (instruction fetch, data load or data store), a data access class, a privilege flag and a real-mode flag. It also carries the result of a block-translation lookup and of a page-table search, both made elsewhere. From the per-segment control nibbles it selects the segment, derives the protection key, decodes page protection and handles direct-store segments. It then returns either a grant with a real address and permission bits, or an exception kind with its architected status word and, for data-side faults, the faulting address.

The fault checks are applied in a fixed order: real mode, block hit, direct-store segment, segment no-execute, page miss, protection. The first check that applies decides the result. The response is registered and appears one cycle after the request. A two-state machine tracks whether a response is being presented. `ST_IDLE` means no response. `ST_DONE` means the output registers hold the verdict for the previous cycle's request. Transition `T_ACCEPT` (`ST_IDLE` to `ST_DONE`) fires on a request. `T_STREAM` (`ST_DONE` to `ST_DONE`) fires on a back-to-back request. `T_DRAIN` (`ST_DONE` to `ST_IDLE`) fires when no request arrives.

Top module: `seg_fault_cls`

## Requirements
- R1: With `req_real`=1 the response grants, with permission 3'b111, `rsp_ra` equal to the effective address and exception kind 0, whatever the other inputs are.
- R2: The segment is chosen by `req_ea[31:28]`. Segment n takes `seg_ctrl[4n+3:4n]`, laid out as bit 3 direct-store, bit 2 supervisor key, bit 1 problem key, bit 0 no-execute.
- R3: The key is the problem key bit when `req_user`=1 and the supervisor key bit otherwise.
- R4: Outside real mode, `blk_hit`=1 takes precedence over every segment check. If `blk_prot` covers the needed right, the response grants with permission `blk_prot` and `rsp_ra`=`blk_ra`. Otherwise a fetch gives instruction fault 0x08000000, a store gives data fault 0x0A000000 and a load gives data fault 0x08000000.
- R5: A fetch from a direct-store segment gives instruction fault 0x10000000.
- R6: In a direct-store segment, data class 1 (floating point) gives alignment exception, code 0. Class 2 (reservation) gives data fault 0x06000000 on a store and 0x04000000 on a load. Class 3 (external control) gives 0x06100000 and 0x04100000. Class 4 (cache management) grants with permission 0 and `rsp_ra` equal to the effective address.
- R7: In a direct-store segment, class 0 (and classes 5 to 7) is integer access, with permission read+write when the key is 1 and read only when it is 0. A granted access returns the effective address. A store denied by the key gives data fault 0x0A000000.
- R8: A fetch from a no-execute segment gives instruction fault 0x10000000, even when no page entry was found.
- R9: On a page miss a fetch gives instruction fault 0x40000000, a store gives data fault 0x42000000 and a load gives data fault 0x40000000.
- R10: Page protection gives read+write for key 0 with pp 0, 1 or 2, and read for key 0 with pp 3. For key 1 it gives none with pp 0, read with pp 1 or 3, and read+write with pp 2. Execute is added unless the segment is no-execute. A denied access is reported as in R4.
- R11: A granted page access returns permission as in R10 and `rsp_ra` = {`pte_rpn`, `req_ea[11:0]`}. A fault returns permission 0 and `rsp_ra` 0.
- R12: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and is 0 after reset. Encodings: kind 0 fetch, 1 load, 2 store, 3 treated as load. Exception 0 none, 1 instruction, 2 data, 3 alignment. Permission bit 0 read, bit 1 write, bit 2 execute. A fetch needs execute, a store write, a load read.
- R13: Data and alignment exceptions set `rsp_far_wr` with `rsp_far` equal to the effective address. Instruction exceptions and grants leave both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind |
| req_class | input | 3 | Data access class for direct-store segments |
| req_user | input | 1 | Unprivileged (problem state) access |
| req_real | input | 1 | Translation off |
| seg_ctrl | input | 64 | Sixteen 4-bit segment control nibbles |
| blk_hit | input | 1 | Block lookup matched |
| blk_prot | input | 3 | Block permission bits |
| blk_ra | input | 32 | Block real address |
| pte_found | input | 1 | Page-table search found an entry |
| pte_pp | input | 2 | Page protection field of the entry |
| pte_rpn | input | 20 | Real page number of the entry |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_perm | output | 3 | Permission bits |
| rsp_ra | output | 32 | Real address |
| rsp_exc | output | 2 | Exception kind |
| rsp_code | output | 32 | Error or status word |
| rsp_far_wr | output | 1 | Faulting address register is loaded |
| rsp_far | output | 32 | Faulting address |

## Verification
Several fault sources often apply to one request in the same cycle, and only the first one in priority may reach the response. One case pairs a block hit with a direct-store segment, and the block result must win. Another pairs a no-execute segment with a page miss on a fetch, and the no-execute code must appear rather than the miss code. A third asserts real mode together with a block hit, and the plain real-mode grant must come out. Each pairing is driven as a single request, and the scoreboard compares the registered verdict one cycle later against the value derived from the priority order.

// File: rtl/seg_fault_pkg.sv
package seg_fault_pkg;

    localparam int CTRL_W      = 4;
    localparam int CTRL_DS     = 3;
    localparam int CTRL_KEY_SV = 2;
    localparam int CTRL_KEY_PR = 1;
    localparam int CTRL_NX     = 0;
    localparam int CODE_W      = 32;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_t;

    typedef enum logic [2:0] {
        DC_INT    = 3'd0,
        DC_FLOAT  = 3'd1,
        DC_RESV   = 3'd2,
        DC_EXTCTL = 3'd3,
        DC_CACHE  = 3'd4
    } data_class_t;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_INSTR = 2'd1,
        EXC_DATA  = 2'd2,
        EXC_ALIGN = 2'd3
    } exc_kind_t;

    localparam logic [2:0] PERM_NONE = 3'b000;
    localparam logic [2:0] PERM_R    = 3'b001;
    localparam logic [2:0] PERM_RW   = 3'b011;
    localparam logic [2:0] PERM_X    = 3'b100;
    localparam logic [2:0] PERM_RWX  = 3'b111;

    localparam logic [CODE_W-1:0] CODE_NX      = 32'h1000_0000;
    localparam logic [CODE_W-1:0] CODE_MISS_I  = 32'h4000_0000;
    localparam logic [CODE_W-1:0] CODE_MISS_L  = 32'h4000_0000;
    localparam logic [CODE_W-1:0] CODE_MISS_S  = 32'h4200_0000;
    localparam logic [CODE_W-1:0] CODE_PROT_I  = 32'h0800_0000;
    localparam logic [CODE_W-1:0] CODE_PROT_L  = 32'h0800_0000;
    localparam logic [CODE_W-1:0] CODE_PROT_S  = 32'h0A00_0000;
    localparam logic [CODE_W-1:0] CODE_RESV_L  = 32'h0400_0000;
    localparam logic [CODE_W-1:0] CODE_RESV_S  = 32'h0600_0000;
    localparam logic [CODE_W-1:0] CODE_EXT_L   = 32'h0410_0000;
    localparam logic [CODE_W-1:0] CODE_EXT_S   = 32'h0610_0000;

    typedef struct packed {
        logic              grant;
        logic [2:0]        perm;
        exc_kind_t         exc;
        logic [CODE_W-1:0] code;
        logic              far_wr;
    } verdict_t;

    function automatic logic [2:0] need_of(acc_kind_t k);
        unique case (k)
            ACC_FETCH: need_of = PERM_X;
            ACC_STORE: need_of = 3'b010;
            ACC_LOAD:  need_of = PERM_R;
            ACC_ALT:   need_of = PERM_R;
        endcase
    endfunction

    function automatic verdict_t grant_v(logic [2:0] p);
        verdict_t v;
        v.grant  = 1'b1;
        v.perm   = p;
        v.exc    = EXC_NONE;
        v.code   = '0;
        v.far_wr = 1'b0;
        return v;
    endfunction

    function automatic verdict_t instr_fault(logic [CODE_W-1:0] c);
        verdict_t v;
        v.grant  = 1'b0;
        v.perm   = PERM_NONE;
        v.exc    = EXC_INSTR;
        v.code   = c;
        v.far_wr = 1'b0;
        return v;
    endfunction

    function automatic verdict_t data_fault(exc_kind_t e, logic [CODE_W-1:0] c);
        verdict_t v;
        v.grant  = 1'b0;
        v.perm   = PERM_NONE;
        v.exc    = e;
        v.code   = c;
        v.far_wr = 1'b1;
        return v;
    endfunction

    function automatic verdict_t prot_deny(acc_kind_t k);
        if (k == ACC_FETCH)      return instr_fault(CODE_PROT_I);
        else if (k == ACC_STORE) return data_fault(EXC_DATA, CODE_PROT_S);
        else                     return data_fault(EXC_DATA, CODE_PROT_L);
    endfunction

    function automatic verdict_t miss_deny(acc_kind_t k);
        if (k == ACC_FETCH)      return instr_fault(CODE_MISS_I);
        else if (k == ACC_STORE) return data_fault(EXC_DATA, CODE_MISS_S);
        else                     return data_fault(EXC_DATA, CODE_MISS_L);
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import seg_fault_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NSEG = 16
) (
    input  logic [NSEG*CTRL_W-1:0] seg_ctrl,
    input  logic [$clog2(NSEG)-1:0] seg_idx,
    input  logic                    user,
    output logic                    seg_ds,
    output logic                    seg_nx,
    output logic                    seg_key
);
    localparam int SEL_W = $clog2(NSEG);

    logic [NSEG-1:0] ds_vec;
    logic [NSEG-1:0] nx_vec;
    logic [NSEG-1:0] ksv_vec;
    logic [NSEG-1:0] kpr_vec;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign ds_vec[g]  = seg_ctrl[g*CTRL_W + CTRL_DS];
        assign nx_vec[g]  = seg_ctrl[g*CTRL_W + CTRL_NX];
        assign ksv_vec[g] = seg_ctrl[g*CTRL_W + CTRL_KEY_SV];
        assign kpr_vec[g] = seg_ctrl[g*CTRL_W + CTRL_KEY_PR];
    end

    always_comb begin
        seg_ds  = ds_vec[seg_idx];
        seg_nx  = nx_vec[seg_idx];
        seg_key = user ? kpr_vec[seg_idx] : ksv_vec[seg_idx];
    end

    if (SEL_W < 1 || AW < SEL_W) begin : g_bad_cfg
        initial $error("seg_select: segment count does not fit the address");
    end

endmodule

// File: rtl/pp_decode.sv
module pp_decode
    import seg_fault_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       nx,
    output logic [2:0] perm
);
    logic [2:0] rw;

    always_comb begin
        unique case ({key, pp})
            3'b000:  rw = PERM_RW;
            3'b001:  rw = PERM_RW;
            3'b010:  rw = PERM_RW;
            3'b011:  rw = PERM_R;
            3'b100:  rw = PERM_NONE;
            3'b101:  rw = PERM_R;
            3'b110:  rw = PERM_RW;
            3'b111:  rw = PERM_R;
        endcase
        perm = nx ? rw : (rw | PERM_X);
    end

endmodule

// File: rtl/ds_path.sv
module ds_path
    import seg_fault_pkg::*;
(
    input  acc_kind_t   kind,
    input  logic [2:0]  dclass,
    input  logic        key,
    output verdict_t    verdict
);
    logic [2:0] int_perm;
    logic [2:0] need;

    always_comb begin
        int_perm = key ? PERM_RW : PERM_R;
        need     = need_of(kind);
        if (kind == ACC_FETCH) begin
            verdict = instr_fault(CODE_NX);
        end else begin
            case (dclass)
                DC_FLOAT:  verdict = data_fault(EXC_ALIGN, '0);
                DC_RESV:   verdict = data_fault(EXC_DATA,
                               (kind == ACC_STORE) ? CODE_RESV_S : CODE_RESV_L);
                DC_EXTCTL: verdict = data_fault(EXC_DATA,
                               (kind == ACC_STORE) ? CODE_EXT_S : CODE_EXT_L);
                DC_CACHE:  verdict = grant_v(PERM_NONE);
                default: begin
                    if ((need & int_perm) == need) verdict = grant_v(int_perm);
                    else                           verdict = prot_deny(kind);
                end
            endcase
        end
    end

endmodule

// File: rtl/seg_fault_cls.sv
module seg_fault_cls
    import seg_fault_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NSEG      = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [AW-1:0]          req_ea,
    input  logic [1:0]             req_kind,
    input  logic [2:0]             req_class,
    input  logic                   req_user,
    input  logic                   req_real,
    input  logic [NSEG*4-1:0]      seg_ctrl,
    input  logic                   blk_hit,
    input  logic [2:0]             blk_prot,
    input  logic [AW-1:0]          blk_ra,
    input  logic                   pte_found,
    input  logic [1:0]             pte_pp,
    input  logic [AW-PAGE_BITS-1:0] pte_rpn,
    output logic                   rsp_valid,
    output logic                   rsp_grant,
    output logic [2:0]             rsp_perm,
    output logic [AW-1:0]          rsp_ra,
    output logic [1:0]             rsp_exc,
    output logic [31:0]            rsp_code,
    output logic                   rsp_far_wr,
    output logic [AW-1:0]          rsp_far
);
    localparam int SEL_W = $clog2(NSEG);
    localparam int RPN_W = AW - PAGE_BITS;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_t;

    state_t state_q;
    state_t state_d;

    acc_kind_t  kind;
    logic       seg_ds;
    logic       seg_nx;
    logic       seg_key;
    logic [2:0] pg_perm;
    logic [2:0] need;
    verdict_t   ds_v;
    verdict_t   v;
    logic [AW-1:0] ra_n;

    assign kind = acc_kind_t'(req_kind);
    assign need = need_of(kind);

    seg_select #(.AW(AW), .NSEG(NSEG)) u_sel (
        .seg_ctrl (seg_ctrl),
        .seg_idx  (req_ea[AW-1 -: SEL_W]),
        .user     (req_user),
        .seg_ds   (seg_ds),
        .seg_nx   (seg_nx),
        .seg_key  (seg_key)
    );

    pp_decode u_pp (
        .key  (seg_key),
        .pp   (pte_pp),
        .nx   (seg_nx),
        .perm (pg_perm)
    );

    ds_path u_ds (
        .kind    (kind),
        .dclass  (req_class),
        .key     (seg_key),
        .verdict (ds_v)
    );

    // Priority chain: real, block, direct store, no-execute, miss, protection
    always_comb begin
        v    = '0;
        ra_n = '0;
        if (req_real) begin
            v    = grant_v(PERM_RWX);
            ra_n = req_ea;
        end else if (blk_hit) begin
            if ((need & blk_prot) == need) begin
                v    = grant_v(blk_prot);
                ra_n = blk_ra;
            end else begin
                v = prot_deny(kind);
            end
        end else if (seg_ds) begin
            v = ds_v;
            if (ds_v.grant) ra_n = req_ea;
        end else if (kind == ACC_FETCH && seg_nx) begin
            v = instr_fault(CODE_NX);
        end else if (!pte_found) begin
            v = miss_deny(kind);
        end else if ((need & pg_perm) == need) begin
            v    = grant_v(pg_perm);
            ra_n = {pte_rpn[RPN_W-1:0], req_ea[PAGE_BITS-1:0]};
        end else begin
            v = prot_deny(kind);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions T_ACCEPT, T_STREAM, T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_valid ? ST_DONE : ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_grant  <= 1'b0;
            rsp_perm   <= '0;
            rsp_ra     <= '0;
            rsp_exc    <= EXC_NONE;
            rsp_code   <= '0;
            rsp_far_wr <= 1'b0;
            rsp_far    <= '0;
        end else begin
            rsp_grant  <= v.grant;
            rsp_perm   <= v.perm;
            rsp_ra     <= ra_n;
            rsp_exc    <= v.exc;
            rsp_code   <= v.code;
            rsp_far_wr <= v.far_wr;
            rsp_far    <= v.far_wr ? req_ea : '0;
        end
    end

    assign rsp_valid = (state_q == ST_DONE);

endmodule

// File: rtl/seg_fault_cls_chk.sv
module seg_fault_cls_chk #(
    parameter int AW        = 32,
    parameter int NSEG      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [AW-1:0]     req_ea,
    input logic [1:0]        req_kind,
    input logic [2:0]        req_class,
    input logic              req_user,
    input logic              req_real,
    input logic [NSEG*4-1:0] seg_ctrl,
    input logic              blk_hit,
    input logic              pte_found,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [2:0]        rsp_perm,
    input logic [AW-1:0]     rsp_ra,
    input logic [1:0]        rsp_exc,
    input logic [31:0]       rsp_code,
    input logic              rsp_far_wr,
    input logic [AW-1:0]     rsp_far
);
    localparam int SEL_W = $clog2(NSEG);

    logic [3:0] nib;
    logic       key;
    logic       seg_path;

    assign nib      = seg_ctrl[req_ea[AW-1 -: SEL_W]*4 +: 4];
    assign key      = req_user ? nib[1] : nib[2];
    assign seg_path = req_valid && !req_real && !blk_hit;

    a_r1_real_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_real) |=> (rsp_grant && rsp_perm == 3'b111
                                     && rsp_ra == $past(req_ea) && rsp_exc == 2'd0));

    a_r12_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r8_noexec_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_path && req_kind == 2'd0 && !nib[3] && nib[0])
            |=> (rsp_exc == 2'd1 && rsp_code == 32'h1000_0000));

    a_r9_store_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_path && req_kind == 2'd2 && !nib[3] && !pte_found)
            |=> (rsp_exc == 2'd2 && rsp_code == 32'h4200_0000));

    a_r7_ds_key0_store: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_path && req_kind == 2'd2 && nib[3] && req_class == 3'd0 && !key)
            |=> (rsp_exc == 2'd2 && rsp_code == 32'h0A00_0000 && !rsp_grant));

    a_r13_isi_no_far: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == 2'd1) |-> !rsp_far_wr);

    a_r13_data_far: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_real) |=> (rsp_far_wr == (rsp_exc[1] == 1'b1))
                                     && (!rsp_far_wr || rsp_far == $past(req_ea)));

    a_r11_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (rsp_exc == 2'd0 && !rsp_far_wr));

endmodule

bind seg_fault_cls seg_fault_cls_chk #(.AW(AW), .NSEG(NSEG)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ea     (req_ea),
    .req_kind   (req_kind),
    .req_class  (req_class),
    .req_user   (req_user),
    .req_real   (req_real),
    .seg_ctrl   (seg_ctrl),
    .blk_hit    (blk_hit),
    .pte_found  (pte_found),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_perm   (rsp_perm),
    .rsp_ra     (rsp_ra),
    .rsp_exc    (rsp_exc),
    .rsp_code   (rsp_code),
    .rsp_far_wr (rsp_far_wr),
    .rsp_far    (rsp_far)
);

// File: tb/test_seg_fault_cls.sv
`timescale 1ns/1ps
module test_seg_fault_cls;

    localparam logic [1:0] KF = 2'd0, KL = 2'd1, KS = 2'd2;
    localparam logic [2:0] CI = 3'd0, CFP = 3'd1, CRV = 3'd2, CEX = 3'd3, CCM = 3'd4;
    localparam logic [1:0] EN = 2'd0, EI = 2'd1, ED = 2'd2, EA = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_class = '0;
    logic        req_user = 1'b0;
    logic        req_real = 1'b0;
    logic [63:0] seg_ctrl = '0;
    logic        blk_hit = 1'b0;
    logic [2:0]  blk_prot = '0;
    logic [31:0] blk_ra = '0;
    logic        pte_found = 1'b0;
    logic [1:0]  pte_pp = '0;
    logic [19:0] pte_rpn = '0;
    logic        rsp_valid, rsp_grant, rsp_far_wr;
    logic [2:0]  rsp_perm;
    logic [31:0] rsp_ra, rsp_code, rsp_far;
    logic [1:0]  rsp_exc;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        grant;
        logic [2:0]  perm;
        logic [31:0] ra;
        logic [1:0]  exc;
        logic [31:0] code;
        logic        far_wr;
        logic [31:0] far;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    seg_fault_cls i_seg_fault_cls (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .req_class(req_class), .req_user(req_user),
        .req_real(req_real), .seg_ctrl(seg_ctrl), .blk_hit(blk_hit),
        .blk_prot(blk_prot), .blk_ra(blk_ra), .pte_found(pte_found),
        .pte_pp(pte_pp), .pte_rpn(pte_rpn), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_perm(rsp_perm), .rsp_ra(rsp_ra),
        .rsp_exc(rsp_exc), .rsp_code(rsp_code), .rsp_far_wr(rsp_far_wr),
        .rsp_far(rsp_far)
    );

    // Driver: one request per call, expected verdict pushed to the scoreboard
    task automatic send(input logic [31:0] ea, input logic [1:0] kind,
                        input logic [2:0] cls, input logic user, input logic rl,
                        input logic bh, input logic [2:0] bp, input logic [31:0] bra,
                        input logic pf, input logic [1:0] pp, input logic [19:0] rpn,
                        input logic eg, input logic [2:0] eperm, input logic [31:0] era,
                        input logic [1:0] eexc, input logic [31:0] ecode,
                        input logic efw, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = kind; req_class = cls;
        req_user = user; req_real = rl; blk_hit = bh; blk_prot = bp; blk_ra = bra;
        pte_found = pf; pte_pp = pp; pte_rpn = rpn;
        e.grant = eg; e.perm = eperm; e.ra = era; e.exc = eexc; e.code = ecode;
        e.far_wr = efw; e.far = efw ? ea : 32'h0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each registered response with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R12: response with nothing expected, got ra=%h exp none", rsp_ra);
            end else begin
                e = sb.pop_front();
                if (rsp_grant !== e.grant || rsp_perm !== e.perm || rsp_ra !== e.ra ||
                    rsp_exc !== e.exc || rsp_code !== e.code ||
                    rsp_far_wr !== e.far_wr || rsp_far !== e.far) begin
                    bad++;
                    $display("FAIL %s: got g=%0b p=%b ra=%h exc=%0d code=%h fw=%0b far=%h exp g=%0b p=%b ra=%h exc=%0d code=%h fw=%0b far=%h",
                             e.tag, rsp_grant, rsp_perm, rsp_ra, rsp_exc, rsp_code,
                             rsp_far_wr, rsp_far, e.grant, e.perm, e.ra, e.exc,
                             e.code, e.far_wr, e.far);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        // seg0 plain, seg1 both keys, seg2 no-exec, seg3 direct store key 0,
        // seg4 direct store supervisor key only, seg5 problem key only
        seg_ctrl[0*4 +: 4] = 4'b0000;
        seg_ctrl[1*4 +: 4] = 4'b0110;
        seg_ctrl[2*4 +: 4] = 4'b0001;
        seg_ctrl[3*4 +: 4] = 4'b1000;
        seg_ctrl[4*4 +: 4] = 4'b1100;
        seg_ctrl[5*4 +: 4] = 4'b0010;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0) begin
            bad++;
            $display("FAIL R12: reset got valid=%0b grant=%0b exp 0 0", rsp_valid, rsp_grant);
        end
        rst_n = 1'b1;

        // R1 real mode wins over a block hit
        send(32'h3000_1234, KS, CI, 0, 1, 1, 3'b001, 32'h5555_0000, 0, 0, 0,
             1, 3'b111, 32'h3000_1234, EN, 0, 0, "R1 real mode");
        // R11 page grant address composition
        send(32'h0000_5ABC, KL, CI, 0, 0, 0, 0, 0, 1, 2'd0, 20'h12345,
             1, 3'b111, 32'h1234_5ABC, EN, 0, 0, "R11 page grant");
        // R10 protection table
        send(32'h0000_7000, KS, CI, 0, 0, 0, 0, 0, 1, 2'd3, 20'h1,
             0, 0, 0, ED, 32'h0A00_0000, 1, "R10 key0 pp3 store");
        send(32'h1000_0040, KL, CI, 0, 0, 0, 0, 0, 1, 2'd0, 20'h1,
             0, 0, 0, ED, 32'h0800_0000, 1, "R10 key1 pp0 load");
        send(32'h1000_2FFF, KS, CI, 0, 0, 0, 0, 0, 1, 2'd2, 20'hABCDE,
             1, 3'b111, 32'hABCD_EFFF, EN, 0, 0, "R10 key1 pp2 store");
        send(32'h1000_3004, KF, CI, 0, 0, 0, 0, 0, 1, 2'd1, 20'h00001,
             1, 3'b101, 32'h0000_1004, EN, 0, 0, "R10 key1 pp1 fetch");
        send(32'h1000_3008, KS, CI, 0, 0, 0, 0, 0, 1, 2'd3, 20'h00001,
             0, 0, 0, ED, 32'h0A00_0000, 1, "R10 key1 pp3 store");
        idle();
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R12: gap got valid=%0b exp 0", rsp_valid);
        end
        // R3 key choice by privilege (R2 segment 5)
        send(32'h5000_0010, KL, CI, 1, 0, 0, 0, 0, 1, 2'd0, 20'h00077,
             0, 0, 0, ED, 32'h0800_0000, 1, "R3 problem key");
        send(32'h5000_0010, KL, CI, 0, 0, 0, 0, 0, 1, 2'd0, 20'h00077,
             1, 3'b111, 32'h0007_7010, EN, 0, 0, "R3 supervisor key");
        // R8 no-execute, including priority over a miss
        send(32'h2000_0100, KF, CI, 0, 0, 0, 0, 0, 1, 2'd0, 20'h00042,
             0, 0, 0, EI, 32'h1000_0000, 0, "R8 nx fetch");
        send(32'h2000_0100, KL, CI, 0, 0, 0, 0, 0, 1, 2'd0, 20'h00042,
             1, 3'b011, 32'h0004_2100, EN, 0, 0, "R10 nx load no exec bit");
        send(32'h2000_0200, KF, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, EI, 32'h1000_0000, 0, "R8 nx before miss");
        // R9 misses
        send(32'h0000_8000, KF, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, EI, 32'h4000_0000, 0, "R9 fetch miss");
        send(32'h0000_8000, KS, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, ED, 32'h4200_0000, 1, "R9 store miss");
        send(32'h0000_8004, KL, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, ED, 32'h4000_0000, 1, "R9 load miss");
        // R4 block path
        send(32'h0123_4567, KL, CI, 0, 0, 1, 3'b001, 32'hABCD_0123, 0, 0, 0,
             1, 3'b001, 32'hABCD_0123, EN, 0, 0, "R4 block load");
        send(32'h0123_4567, KS, CI, 0, 0, 1, 3'b001, 32'hABCD_0123, 0, 0, 0,
             0, 0, 0, ED, 32'h0A00_0000, 1, "R4 block store deny");
        send(32'h0123_4567, KF, CI, 0, 0, 1, 3'b011, 32'hABCD_0123, 0, 0, 0,
             0, 0, 0, EI, 32'h0800_0000, 0, "R4 block fetch deny");
        send(32'h3000_0008, KL, CFP, 0, 0, 1, 3'b011, 32'h8000_0008, 0, 0, 0,
             1, 3'b011, 32'h8000_0008, EN, 0, 0, "R4 block over direct store");
        // R5 / R6 direct store
        send(32'h3000_0100, KF, CI, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, EI, 32'h1000_0000, 0, "R5 ds fetch");
        send(32'h3000_0200, KL, CFP, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, EA, 32'h0, 1, "R6 ds float");
        send(32'h3000_0200, KS, CRV, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, ED, 32'h0600_0000, 1, "R6 ds resv store");
        send(32'h3000_0204, KL, CRV, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, ED, 32'h0400_0000, 1, "R6 ds resv load");
        send(32'h3000_0208, KS, CEX, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, ED, 32'h0610_0000, 1, "R6 ds ext store");
        send(32'h3000_020C, KL, CEX, 0, 0, 0, 0, 0, 1, 0, 0,
             0, 0, 0, ED, 32'h0410_0000, 1, "R6 ds ext load");
        send(32'h3000_0210, KS, CCM, 0, 0, 0, 0, 0, 1, 0, 0,
             1, 3'b000, 32'h3000_0210, EN, 0, 0, "R6 ds cache noop");
        // R7 direct store integer with keys
        send(32'h3000_0300, KL, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             1, 3'b001, 32'h3000_0300, EN, 0, 0, "R7 ds int load key0");
        send(32'h3000_0304, KS, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, ED, 32'h0A00_0000, 1, "R7 ds int store key0");
        send(32'h4000_0300, KS, CI, 0, 0, 0, 0, 0, 0, 0, 0,
             1, 3'b011, 32'h4000_0300, EN, 0, 0, "R7 ds int store key1");
        send(32'h4000_0304, KS, CI, 1, 0, 0, 0, 0, 0, 0, 0,
             0, 0, 0, ED, 32'h0A00_0000, 1, "R7 ds problem key0 R2");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0 || rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R12: drain got pending=%0d valid=%0b exp 0 0", sb.size(), rsp_valid);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule